// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block sits behind the two-address byte port of an eight-line interrupt controller. It decodes every write and read on that port. It steps through the initialisation word sequence, in which the fourth word is optional. It carries out the operation commands: the end-of-interrupt variants, priority rotation, the register-read selector, special mask and poll. It also loads the mask register once the controller is in normal operation. Its outputs are the programmed state, for the arbitration and request logic around it to use.

Priority arbitration stays outside the block. The neighbouring arbiter supplies two results:
- the highest-priority in-service line, used by the non-specific end-of-interrupt commands;
- the winning requesting line, used by a poll read.

The pending register also lives outside. A poll read asks the outside logic to drop the winning line's pending bit through a one-hot clear output. The in-service register is held here. External acknowledge logic sets its bits, and the commands of this block clear them.

Only one strobe may be active in a cycle. A write takes effect at the rising clock edge. Read data and the poll clear vector are combinational from the present state and inputs.

Top module: `irq_cmd_seq`

## Requirements
- R1: After synchronous reset, every programmed state is zero: mask, vector base, special nested, auto-EOI, rotate-on-auto-EOI, rotation offset, read select, special mask, poll flag and in-service register. The controller is in normal operation, so a write to address 1 loads the mask.
- R2: A write to address 0 with data bit 4 set starts initialisation. It clears the mask, the rotation offset, the special mask and the read select, and it records data bit 0 as "fourth word expected". When bit 0 is 1, special nested and auto-EOI keep their values. The next write to address 1 is taken as the vector base word.
- R3: When initialisation starts with data bit 0 clear, special nested and auto-EOI are cleared. The sequence is then base word, second word, normal operation: the third write to address 1 loads the mask.
- R4: When a fourth word is expected, the third write to address 1 loads special nested from data bit 4 and auto-EOI from data bit 1. Normal operation follows. The base word's data bits 7:3 become the 5-bit vector base.
- R5: In normal operation a write to address 1 loads the 8-bit mask. A non-poll read of address 1 returns the mask.
- R6: A write to address 0 with bit 4 clear and bit 3 set is a control command, with three independent effects:
  - bit 2 set arms poll;
  - bit 1 set loads the read select from bit 0;
  - bit 6 set loads the special mask from bit 5.
- R7: A non-poll read of address 0 returns the in-service register when read select is 1, and the pending input otherwise.
- R8: A write to address 0 with bits 4:3 clear is a command coded in bits 7:5. Code 4 sets rotate-on-auto-EOI and code 0 clears it.
- R9: Any bit set in the in-service set input is set in the in-service register at the next edge. Command code 1 clears the in-service bit of the supplied highest in-service line. When the line-valid input is low, code 1 changes nothing.
- R10: Command code 5 clears that same in-service bit and sets the rotation offset to (line+1) mod 8. When the line-valid input is low, code 5 changes nothing.
- R11: Command code 3 clears the in-service bit named by data bits 2:0. Code 7 clears it and also sets the rotation offset to (bits 2:0 + 1) mod 8.
- R12: Command code 6 sets the rotation offset to (data bits 2:0 + 1) mod 8. It leaves the in-service register unchanged.
- R13: Command code 2 is ignored. In-service, rotation offset, rotate-on-auto-EOI, mask, read select and poll flag are all unchanged.
- R14: A read while poll is armed works as follows:
  - with a winning line, it returns that line number (0 to 7), drives a one-hot pending clear for it in the same cycle, and clears its in-service bit;
  - with no winning line, it returns 7 and clears nothing;
  - in either case, poll is disarmed after that one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 1 | Register port address bit |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| pend_i | input | 8 | Pending register from the request logic |
| svc_set_i | input | 8 | In-service bits to set (acknowledge) |
| top_valid_i | input | 1 | An in-service line exists |
| top_line_i | input | 3 | Highest-priority in-service line |
| win_valid_i | input | 1 | A requesting line wins arbitration |
| win_line_i | input | 3 | Winning requesting line |
| rdata_o | output | 8 | Read data |
| pend_clr_o | output | 8 | One-hot pending clear on a poll read |
| svc_o | output | 8 | In-service register |
| mask_o | output | 8 | Mask register |
| vbase_o | output | 5 | Vector base |
| nested_o | output | 1 | Special nested mode |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| rot_off_o | output | 3 | Priority rotation offset |
| rsel_o | output | 1 | Read select (1 = in-service) |
| smask_o | output | 1 | Special mask mode |
| poll_o | output | 1 | Poll armed |

## Verification
Each write changes a register output at the first rising edge after the strobe. The bench drives the write on a falling edge and checks the outputs at the next falling edge, after exactly one edge has passed. Read data and the poll clear vector are due in the same cycle as the read strobe, so they are sampled 2 ns after the strobe is driven, before any edge. The in-service and poll changes that a poll read causes are checked one cycle later. Commands that are ignored, or that find no valid line, are checked by reading the affected state on the ports after the write.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;

    localparam int NUM_LINES = 8;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int DATA_W    = 8;
    localparam int BASE_W    = DATA_W - LINE_W;
    localparam int CODE_W    = 3;
    localparam int HEAD_W    = DATA_W - LINE_W;

    typedef logic [NUM_LINES-1:0] line_vec_t;
    typedef logic [LINE_W-1:0]    line_t;
    typedef logic [DATA_W-1:0]    byte_t;
    typedef logic [BASE_W-1:0]    base_t;

    // returned by a poll read when nothing requests
    localparam line_t IDLE_LINE = line_t'(NUM_LINES - 1);

    typedef enum logic [3:0] {
        OP_NONE,
        OP_INIT,
        OP_CTRL,
        OP_RAEOI_CLR,
        OP_RAEOI_SET,
        OP_EOI_TOP,
        OP_EOI_TOP_ROT,
        OP_EOI_LINE,
        OP_SET_LOW,
        OP_EOI_LINE_ROT,
        OP_DATA
    } op_e;

    typedef enum logic [1:0] {
        STEP_RUN,
        STEP_BASE,
        STEP_SKIP,
        STEP_MODE
    } step_e;

    typedef struct packed {
        line_vec_t mask;
        base_t     vbase;
        logic      nested;
        logic      auto_eoi;
        logic      rot_aeoi;
        line_t     rot_off;
        logic      rsel;
        logic      smask;
        logic      poll;
    } cfg_t;

    function automatic line_vec_t line_bit(line_t l);
        return line_vec_t'(1) << l;
    endfunction

    function automatic line_t next_line(line_t l);
        return l + line_t'(1);
    endfunction

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_cmd_pkg::*;
(
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [HEAD_W-1:0] head_i,
    output op_e               op_o
);
    // head_i carries data bits 7:3; the command code is its top three bits
    logic [CODE_W-1:0] code;
    assign code = head_i[HEAD_W-1 -: CODE_W];

    always_comb begin
        op_o = OP_NONE;
        if (wr_i) begin
            if (addr_i) begin
                op_o = OP_DATA;
            end else if (head_i[1]) begin
                op_o = OP_INIT;
            end else if (head_i[0]) begin
                op_o = OP_CTRL;
            end else begin
                unique case (code)
                    3'd0:    op_o = OP_RAEOI_CLR;
                    3'd1:    op_o = OP_EOI_TOP;
                    3'd3:    op_o = OP_EOI_LINE;
                    3'd4:    op_o = OP_RAEOI_SET;
                    3'd5:    op_o = OP_EOI_TOP_ROT;
                    3'd6:    op_o = OP_SET_LOW;
                    3'd7:    op_o = OP_EOI_LINE_ROT;
                    default: op_o = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
    import irq_cmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op_i,
    input  logic  want4_i,
    output step_e step_o
);
    step_e step_q, step_d;
    logic  want4_q, want4_d;

    always_comb begin
        step_d  = step_q;
        want4_d = want4_q;
        if (op_i == OP_INIT) begin
            step_d  = STEP_BASE;
            want4_d = want4_i;
        end else if (op_i == OP_DATA) begin
            unique case (step_q)
                STEP_BASE: step_d = STEP_SKIP;
                STEP_SKIP: step_d = want4_q ? STEP_MODE : STEP_RUN;
                STEP_MODE: step_d = STEP_RUN;
                default:   step_d = STEP_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= STEP_RUN;
            want4_q <= 1'b0;
        end else begin
            step_q  <= step_d;
            want4_q <= want4_d;
        end
    end

    assign step_o = step_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_cmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op_i,
    input  byte_t wdata_i,
    input  step_e step_i,
    input  logic  rd_i,
    input  logic  top_valid_i,
    input  line_t top_line_i,
    output cfg_t  cfg_o
);
    cfg_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (rd_i) nxt.poll = 1'b0;
        unique case (op_i)
            OP_INIT: begin
                nxt.mask    = '0;
                nxt.rot_off = '0;
                nxt.smask   = 1'b0;
                nxt.rsel    = 1'b0;
                if (!wdata_i[0]) begin
                    nxt.nested   = 1'b0;
                    nxt.auto_eoi = 1'b0;
                end
            end
            OP_CTRL: begin
                if (wdata_i[2]) nxt.poll  = 1'b1;
                if (wdata_i[1]) nxt.rsel  = wdata_i[0];
                if (wdata_i[6]) nxt.smask = wdata_i[5];
            end
            OP_RAEOI_CLR: nxt.rot_aeoi = 1'b0;
            OP_RAEOI_SET: nxt.rot_aeoi = 1'b1;
            OP_EOI_TOP_ROT: begin
                if (top_valid_i) nxt.rot_off = next_line(top_line_i);
            end
            OP_SET_LOW, OP_EOI_LINE_ROT: begin
                nxt.rot_off = next_line(wdata_i[LINE_W-1:0]);
            end
            OP_DATA: begin
                unique case (step_i)
                    STEP_RUN:  nxt.mask  = wdata_i;
                    STEP_BASE: nxt.vbase = wdata_i[DATA_W-1:LINE_W];
                    STEP_MODE: begin
                        nxt.nested   = wdata_i[4];
                        nxt.auto_eoi = wdata_i[1];
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end

    assign cfg_o = cur_q;

endmodule

// File: rtl/irq_svc_reg.sv
module irq_svc_reg
    import irq_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  op_e       op_i,
    input  line_t     sel_line_i,
    input  logic      top_valid_i,
    input  line_t     top_line_i,
    input  line_vec_t set_i,
    input  line_vec_t poll_clr_i,
    output line_vec_t svc_o
);
    line_vec_t svc_q, clr;

    always_comb begin
        clr = poll_clr_i;
        unique case (op_i)
            OP_EOI_TOP, OP_EOI_TOP_ROT: begin
                if (top_valid_i) clr = clr | line_bit(top_line_i);
            end
            OP_EOI_LINE, OP_EOI_LINE_ROT: clr = clr | line_bit(sel_line_i);
            default: ;
        endcase
    end

    // a clear in the same cycle as a set of the same bit wins
    always_ff @(posedge clk) begin
        if (rst) svc_q <= '0;
        else     svc_q <= (svc_q | set_i) & ~clr;
    end

    assign svc_o = svc_q;

endmodule

// File: rtl/irq_cmd_seq.sv
module irq_cmd_seq
    import irq_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        addr_i,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic [7:0]  wdata_i,
    input  logic [7:0]  pend_i,
    input  logic [7:0]  svc_set_i,
    input  logic        top_valid_i,
    input  logic [2:0]  top_line_i,
    input  logic        win_valid_i,
    input  logic [2:0]  win_line_i,
    output logic [7:0]  rdata_o,
    output logic [7:0]  pend_clr_o,
    output logic [7:0]  svc_o,
    output logic [7:0]  mask_o,
    output logic [4:0]  vbase_o,
    output logic        nested_o,
    output logic        auto_eoi_o,
    output logic        rot_aeoi_o,
    output logic [2:0]  rot_off_o,
    output logic        rsel_o,
    output logic        smask_o,
    output logic        poll_o
);
    op_e       op;
    step_e     step;
    cfg_t      cfg;
    line_vec_t svc;
    line_vec_t poll_clr;
    logic      poll_hit;

    irq_cmd_decode u_decode (
        .wr_i   (wr_i),
        .addr_i (addr_i),
        .head_i (wdata_i[DATA_W-1:LINE_W]),
        .op_o   (op)
    );

    irq_init_fsm u_init (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op),
        .want4_i (wdata_i[0]),
        .step_o  (step)
    );

    irq_cfg_regs u_cfg (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op),
        .wdata_i     (wdata_i),
        .step_i      (step),
        .rd_i        (rd_i),
        .top_valid_i (top_valid_i),
        .top_line_i  (top_line_i),
        .cfg_o       (cfg)
    );

    assign poll_hit = rd_i & cfg.poll;
    assign poll_clr = (poll_hit && win_valid_i) ? line_bit(win_line_i) : '0;

    irq_svc_reg u_svc (
        .clk         (clk),
        .rst         (rst),
        .op_i        (op),
        .sel_line_i  (wdata_i[LINE_W-1:0]),
        .top_valid_i (top_valid_i),
        .top_line_i  (top_line_i),
        .set_i       (svc_set_i),
        .poll_clr_i  (poll_clr),
        .svc_o       (svc)
    );

    always_comb begin
        if (poll_hit)
            rdata_o = win_valid_i ? byte_t'(win_line_i) : byte_t'(IDLE_LINE);
        else if (addr_i)
            rdata_o = cfg.mask;
        else if (cfg.rsel)
            rdata_o = svc;
        else
            rdata_o = pend_i;
    end

    assign pend_clr_o = poll_clr;
    assign svc_o      = svc;
    assign mask_o     = cfg.mask;
    assign vbase_o    = cfg.vbase;
    assign nested_o   = cfg.nested;
    assign auto_eoi_o = cfg.auto_eoi;
    assign rot_aeoi_o = cfg.rot_aeoi;
    assign rot_off_o  = cfg.rot_off;
    assign rsel_o     = cfg.rsel;
    assign smask_o    = cfg.smask;
    assign poll_o     = cfg.poll;

endmodule

// File: rtl/irq_cmd_seq_chk.sv
module irq_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       addr_i,
    input logic       wr_i,
    input logic       rd_i,
    input logic [7:0] wdata_i,
    input logic [7:0] svc_set_i,
    input logic [7:0] pend_clr_o,
    input logic [7:0] svc_o,
    input logic [7:0] mask_o,
    input logic       nested_o,
    input logic       auto_eoi_o,
    input logic [2:0] rot_off_o,
    input logic       rsel_o,
    input logic       smask_o,
    input logic       poll_o
);
    logic cmd_wr;
    assign cmd_wr = wr_i && !addr_i && (wdata_i[4:3] == 2'b00);

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !addr_i && wdata_i[4]) |=>
        (mask_o == 8'h00 && rot_off_o == 3'd0 && !smask_o && !rsel_o)); // R2

    AST_INIT_NO_FOURTH: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !addr_i && wdata_i[4] && !wdata_i[0]) |=>
        (!nested_o && !auto_eoi_o)); // R3

    AST_CTRL_RSEL: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !addr_i && !wdata_i[4] && wdata_i[3] && wdata_i[1]) |=>
        (rsel_o == $past(wdata_i[0]))); // R6

    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata_i[6:5] == 2'b11) |=>
        !svc_o[$past(wdata_i[2:0])]); // R11

    AST_SET_LOW: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata_i[7:5] == 3'd6) |=>
        (rot_off_o == 3'($past(wdata_i[2:0]) + 3'd1))); // R12

    AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && wdata_i[7:5] == 3'd2 && svc_set_i == 8'h00 && !rd_i) |=>
        ($stable(svc_o) && $stable(rot_off_o) && $stable(mask_o) && $stable(poll_o))); // R13

    AST_POLL_DISARM: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> !poll_o); // R14

    AST_POLL_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pend_clr_o)); // R14

    AST_POLL_CLR_SRC: assert property (@(posedge clk) disable iff (rst)
        (pend_clr_o != 8'h00) |-> (rd_i && poll_o)); // R14

endmodule

bind irq_cmd_seq irq_cmd_seq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .svc_set_i  (svc_set_i),
    .pend_clr_o (pend_clr_o),
    .svc_o      (svc_o),
    .mask_o     (mask_o),
    .nested_o   (nested_o),
    .auto_eoi_o (auto_eoi_o),
    .rot_off_o  (rot_off_o),
    .rsel_o     (rsel_o),
    .smask_o    (smask_o),
    .poll_o     (poll_o)
);

// File: tb/test_irq_cmd_seq.sv
module test_irq_cmd_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr = 1'b0, wr_s = 1'b0, rd_s = 1'b0;
    logic [7:0] wdata = '0, pend = '0, svc_set = '0;
    logic       topv = 1'b0, winv = 1'b0;
    logic [2:0] topl = '0, winl = '0;
    logic [7:0] rdata, pclr, svc, mask;
    logic [4:0] vbase;
    logic       nested, aeoi, raeoi, rsel, smask, poll;
    logic [2:0] rot;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    irq_cmd_seq i_irq_cmd_seq (
        .clk(clk), .rst(rst), .addr_i(addr), .wr_i(wr_s), .rd_i(rd_s),
        .wdata_i(wdata), .pend_i(pend), .svc_set_i(svc_set),
        .top_valid_i(topv), .top_line_i(topl),
        .win_valid_i(winv), .win_line_i(winl),
        .rdata_o(rdata), .pend_clr_o(pclr), .svc_o(svc), .mask_o(mask),
        .vbase_o(vbase), .nested_o(nested), .auto_eoi_o(aeoi),
        .rot_aeoi_o(raeoi), .rot_off_o(rot), .rsel_o(rsel),
        .smask_o(smask), .poll_o(poll)
    );

    typedef struct packed {
        logic       is_rd;
        logic       a;
        logic [7:0] data;
        logic [7:0] pnd;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 8'h11, 8'h00, 8'h00, 4'd2},  // R2 init, fourth word
        '{1'b1, 1'b1, 8'h00, 8'h00, 8'h00, 4'd2},  // R2 mask cleared
        '{1'b0, 1'b1, 8'h48, 8'h00, 8'h00, 4'd4},  // R4 base word
        '{1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 4'd4},  // R4 second word
        '{1'b0, 1'b1, 8'h12, 8'h00, 8'h00, 4'd4},  // R4 mode word
        '{1'b0, 1'b1, 8'hA5, 8'h00, 8'h00, 4'd5},  // R5 mask write
        '{1'b1, 1'b1, 8'h00, 8'h00, 8'hA5, 4'd5},  // R5 mask read
        '{1'b1, 1'b0, 8'h00, 8'h3C, 8'h3C, 4'd7},  // R7 pending view
        '{1'b0, 1'b0, 8'h0B, 8'h00, 8'h00, 4'd6},  // R6 select in-service
        '{1'b1, 1'b0, 8'h00, 8'h3C, 8'h00, 4'd7},  // R7 in-service view
        '{1'b0, 1'b0, 8'h0A, 8'h00, 8'h00, 4'd6},  // R6 select pending
        '{1'b1, 1'b0, 8'h00, 8'h81, 8'h81, 4'd7},  // R7 pending view
        '{1'b0, 1'b0, 8'h10, 8'h00, 8'h00, 4'd3},  // R3 init, no fourth
        '{1'b0, 1'b1, 8'h20, 8'h00, 8'h00, 4'd3},  // R3 base word
        '{1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 4'd3},  // R3 second word
        '{1'b0, 1'b1, 8'h0F, 8'h00, 8'h00, 4'd3},  // R3 lands in mask
        '{1'b1, 1'b1, 8'h00, 8'h00, 8'h0F, 4'd3}   // R3 mask read
    };

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_wr(logic a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_s = 1'b1;
        @(negedge clk);
        wr_s = 1'b0;
    endtask

    task automatic do_rd(logic a, output logic [7:0] v, output logic [7:0] c);
        @(negedge clk);
        addr = a; rd_s = 1'b1;
        #2;
        v = rdata; c = pclr;
        @(negedge clk);
        rd_s = 1'b0;
    endtask

    task automatic pulse_set(logic [7:0] v);
        @(negedge clk);
        svc_set = v;
        @(negedge clk);
        svc_set = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all-requirements: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1", "mask", mask, 0);       check("R1", "vbase", vbase, 0);
        check("R1", "nested", nested, 0);   check("R1", "aeoi", aeoi, 0);
        check("R1", "raeoi", raeoi, 0);     check("R1", "rot", rot, 0);
        check("R1", "rsel", rsel, 0);       check("R1", "smask", smask, 0);
        check("R1", "poll", poll, 0);       check("R1", "svc", svc, 0);
        do_wr(1'b1, 8'h81);
        check("R1", "normal mask load", mask, 8'h81);

        for (int i = 0; i < NVEC; i++) begin
            pend = VECS[i].pnd;
            if (VECS[i].is_rd) begin
                do_rd(VECS[i].a, v, c);
                check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i), v, VECS[i].exp);
            end else begin
                do_wr(VECS[i].a, VECS[i].data);
            end
        end
        pend = '0;
        check("R3", "vbase", vbase, 5'd4);
        check("R3", "nested", nested, 0);
        check("R3", "aeoi", aeoi, 0);

        // R6 control, R12 rotation, R5 mask
        do_wr(1'b0, 8'h68); check("R6", "smask set", smask, 1);
        do_wr(1'b0, 8'h0B); check("R6", "rsel set", rsel, 1);
        do_wr(1'b0, 8'hC2); check("R12", "rot", rot, 3);
        do_wr(1'b1, 8'h77); check("R5", "mask", mask, 8'h77);

        // R2 init clears
        do_wr(1'b0, 8'h13);
        check("R2", "mask", mask, 0);   check("R2", "rot", rot, 0);
        check("R2", "smask", smask, 0); check("R2", "rsel", rsel, 0);
        do_wr(1'b1, 8'h48); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h12);
        check("R4", "vbase", vbase, 5'd9);
        check("R4", "nested", nested, 1);
        check("R4", "aeoi", aeoi, 1);
        do_wr(1'b1, 8'h5A);
        do_rd(1'b1, v, c); check("R5", "mask read", v, 8'h5A);

        do_wr(1'b0, 8'h11);
        check("R2", "nested kept", nested, 1);
        check("R2", "aeoi kept", aeoi, 1);
        do_wr(1'b1, 8'h08); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h00);
        check("R4", "nested cleared by mode word", nested, 0);
        check("R4", "aeoi cleared by mode word", aeoi, 0);
        check("R4", "mask untouched by mode word", mask, 0);

        do_wr(1'b0, 8'h10); do_wr(1'b1, 8'h20); do_wr(1'b1, 8'h00); do_wr(1'b1, 8'h3C);
        do_rd(1'b1, v, c); check("R3", "third word to mask", v, 8'h3C);

        // R14 poll
        do_wr(1'b0, 8'h0C); check("R6", "poll armed", poll, 1);
        pulse_set(8'h10);
        pend = 8'h10; winv = 1'b1; winl = 3'd4;
        do_rd(1'b0, v, c);
        check("R14", "poll line", v, 8'h04);
        check("R14", "poll pend clear", c, 8'h10);
        check("R14", "poll disarmed", poll, 0);
        check("R14", "svc cleared", svc, 8'h00);
        do_wr(1'b0, 8'h0C);
        winv = 1'b0; pend = 8'h00;
        do_rd(1'b0, v, c);
        check("R14", "idle poll code", v, 8'h07);
        check("R14", "idle poll no clear", c, 8'h00);
        pend = 8'h55;
        do_rd(1'b0, v, c);
        check("R14", "after poll normal read", v, 8'h55);
        check("R14", "no clear outside poll", c, 8'h00);
        pend = 8'h00;

        // R9 set and non-specific clear
        pulse_set(8'h2C); check("R9", "svc set", svc, 8'h2C);
        topv = 1'b1; topl = 3'd3;
        do_wr(1'b0, 8'h20); check("R9", "top cleared", svc, 8'h24);
        topv = 1'b0;
        do_wr(1'b0, 8'h20); check("R9", "no valid line", svc, 8'h24);

        // R10 rotating non-specific
        topv = 1'b1; topl = 3'd5;
        do_wr(1'b0, 8'hA0);
        check("R10", "svc", svc, 8'h04); check("R10", "rot", rot, 6);
        topv = 1'b0;
        do_wr(1'b0, 8'hA0);
        check("R10", "rot kept", rot, 6); check("R10", "svc kept", svc, 8'h04);

        // R11 specific
        do_wr(1'b0, 8'h62); check("R11", "specific clear", svc, 8'h00);
        pulse_set(8'h08);
        do_wr(1'b0, 8'hE3);
        check("R11", "rot specific svc", svc, 8'h00);
        check("R11", "rot specific offset", rot, 4);

        // R12 set lowest
        pulse_set(8'h01);
        do_wr(1'b0, 8'hC7);
        check("R12", "rot wrap", rot, 0); check("R12", "svc kept", svc, 8'h01);

        // R8 rotate on auto-EOI
        do_wr(1'b0, 8'h80); check("R8", "set", raeoi, 1);
        do_wr(1'b0, 8'h00); check("R8", "clear", raeoi, 0);
        do_wr(1'b0, 8'h80);

        // R13 ignored code
        do_wr(1'b0, 8'h40);
        check("R13", "svc", svc, 8'h01);  check("R13", "rot", rot, 0);
        check("R13", "raeoi", raeoi, 1);  check("R13", "poll", poll, 0);
        check("R13", "rsel", rsel, 0);
        do_rd(1'b1, v, c); check("R13", "mask", v, 8'h3C);

        // R7 in-service view
        do_wr(1'b0, 8'h0B);
        pend = 8'hFF;
        do_rd(1'b0, v, c); check("R7", "svc view", v, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule